// File: doc/BRIEF.md
# Five-Dimensional Strided Tensor Address Walker

This block produces the byte addresses needed to visit every element of a five-dimensional tensor stored in memory. The dimensions, from fastest to slowest, are column, row, plane, depth and group. Column elements sit back to back at the size of one element, which the element kind sets. Each of the four slower dimensions has its own programmed stride. A bank of base addresses is loaded ahead of time, and a select input picks one of them for each walk.

A one-cycle start pulse samples the element kind, the five extents, the four strides and the chosen base. The block then offers one address per valid/ready handshake and marks the final element with a last flag. If a stride is not on a 64-byte boundary, or the element kind code is unknown, the walk is refused and an error level is raised. A walk with any extent of zero finishes at once and emits nothing.

Top module: `tensor_addr_walker`

## Requirements
- R1: After synchronous reset, addr_valid, busy and cfg_err are all low.
- R2: The n-th accepted address equals base + c*E + r*S1 + p*S2 + d*S3 + g*S4. The column index c runs fastest and the group index g slowest. Each index returns to zero after reaching its extent minus one, and that carries into the next index. The extents are packed in cfg_extent with column in the lowest slice and group in the highest. The strides are packed in cfg_stride as slices 1 (row) to 4 (group).
- R3: The element size E is 1 byte for cfg_kind 0 (unsigned 8-bit) and 1 (signed 8-bit), and 2 bytes for cfg_kind 2 (16-bit float). cfg_kind 3 is refused as a configuration error.
- R4: A start with any stride whose low six bits are not zero sets cfg_err from the next cycle on. It issues no address and leaves busy low. cfg_err stays high until the next start taken while idle.
- R5: Eight base registers are written through base_wr_en, base_wr_idx and base_wr_data. The base_sel value sampled at start picks the base for that walk.
- R6: addr_last is high only on the final element. Once that element is accepted, busy and addr_valid are low in the next cycle.
- R7: A start with any extent of zero leaves busy, addr_valid and cfg_err low.
- R8: While addr_valid is high and addr_ready is low, addr, addr_last and addr_valid keep their values into the next cycle.
- R9: Once a walk is running, changes on the configuration inputs and start pulses have no effect on the addresses it issues.
- R10: After an accepted start with a valid, non-empty configuration, addr_valid is high in the next cycle and carries the base address.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the base bank |
| base_wr_idx | input | 3 | Base register to write |
| base_wr_data | input | ADDR_W | Base address value to store |
| start | input | 1 | Launches a walk while idle |
| base_sel | input | 3 | Base register used by the walk |
| cfg_kind | input | 2 | Element kind code |
| cfg_extent | input | 5*EXT_W | Extents, column in the lowest slice |
| cfg_stride | input | 4*ADDR_W | Strides of row, plane, depth, group |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | Address output is valid |
| addr | output | ADDR_W | Current byte address |
| addr_last | output | 1 | Current address is the final element |
| busy | output | 1 | Walk in progress |
| cfg_err | output | 1 | Last start was refused |

## Verification
The bench builds the walker with EXT_W set to 4, which keeps every walk short enough to check element by element. It keeps ADDR_W at 32 and all eight base registers, so a base just below 2^32 reaches the wraparound case, and every select value can be written and used. Walks mix extents of one with extents of several, so each level of the carry chain fires both alone and alongside the lower levels.

// File: rtl/twalk_pkg.sv
package twalk_pkg;

    localparam int NDIM       = 5;
    localparam int ALIGN_BITS = 6;

    typedef enum logic [1:0] {
        ELEM_U8  = 2'd0,
        ELEM_S8  = 2'd1,
        ELEM_F16 = 2'd2,
        ELEM_RSV = 2'd3
    } elem_kind_e;

    typedef struct packed {
        logic bad_kind;
        logic bad_align;
        logic empty;
    } launch_chk_t;

    function automatic logic [1:0] elem_bytes(input elem_kind_e kind);
        case (kind)
            ELEM_F16: elem_bytes = 2'd2;
            default:  elem_bytes = 2'd1;
        endcase
    endfunction

    function automatic logic kind_known(input elem_kind_e kind);
        kind_known = (kind != ELEM_RSV);
    endfunction

endpackage

// File: rtl/twalk_base_bank.sv
module twalk_base_bank #(
    parameter int AW = 32,
    parameter int NB = 8,
    localparam int SW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [SW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [AW-1:0] slot [NB];

    for (genvar i = 0; i < NB; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (wr_en && (wr_idx == SW'(i)))
                slot[i] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/twalk_cfg_check.sv
module twalk_cfg_check
    import twalk_pkg::*;
#(
    parameter int AW = 32,
    parameter int EW = 16
) (
    input  elem_kind_e                    kind,
    input  logic [NDIM-1:0][EW-1:0]       extent,
    input  logic [NDIM-1:1][AW-1:0]       stride,
    output launch_chk_t                   chk
);
    logic [NDIM-1:0] ext_zero;
    logic [NDIM-1:1] str_off;

    for (genvar d = 0; d < NDIM; d++) begin : g_ext
        assign ext_zero[d] = (extent[d] == '0);
    end

    for (genvar k = 1; k < NDIM; k++) begin : g_str
        assign str_off[k] = |stride[k][ALIGN_BITS-1:0];
    end

    always_comb begin
        chk.bad_kind  = !kind_known(kind);
        chk.bad_align = |str_off;
        chk.empty     = |ext_zero;
    end
endmodule

// File: rtl/twalk_odometer.sv
module twalk_odometer
    import twalk_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    step,
    input  logic [NDIM-1:0][EW-1:0] ext,
    output logic [NDIM-1:0]         bump,
    output logic                    col_wrap,
    output logic                    last
);
    logic [EW-1:0]   idx [NDIM];
    logic [NDIM-1:0] wrap;
    logic [NDIM-1:0] inc;

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        assign wrap[d] = (idx[d] == (ext[d] - 1'b1));

        if (d == 0) begin : g_first
            assign inc[d] = 1'b1;
        end else begin : g_rest
            assign inc[d] = inc[d-1] & wrap[d-1];
        end

        assign bump[d] = inc[d] & ~wrap[d];

        always_ff @(posedge clk) begin
            if (rst || load)
                idx[d] <= '0;
            else if (step && inc[d])
                idx[d] <= wrap[d] ? '0 : idx[d] + 1'b1;
        end
    end

    assign col_wrap = wrap[0];
    assign last     = &wrap;
endmodule

// File: rtl/twalk_addr_accum.sv
module twalk_addr_accum
    import twalk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [AW-1:0]           base,
    input  logic                    step,
    input  logic [NDIM-1:0]         bump,
    input  logic [1:0]              esz,
    input  logic [NDIM-1:1][AW-1:0] stride,
    output logic [AW-1:0]           addr
);
    logic [AW-1:0]   line_base [NDIM-1:1];
    logic [AW-1:0]   jump;
    logic [NDIM-1:1] reach;

    always_comb begin
        jump = '0;
        for (int k = 1; k < NDIM; k++) begin
            if (bump[k])
                jump = line_base[k] + stride[k];
        end
    end

    for (genvar j = 1; j < NDIM; j++) begin : g_line
        assign reach[j] = |bump[NDIM-1:j];

        always_ff @(posedge clk) begin
            if (rst)
                line_base[j] <= '0;
            else if (load)
                line_base[j] <= base;
            else if (step && reach[j])
                line_base[j] <= jump;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step)
            addr <= bump[0] ? addr + {{(AW-2){1'b0}}, esz} : jump;
    end
endmodule

// File: rtl/tensor_addr_walker.sv
module tensor_addr_walker
    import twalk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int EXT_W     = 16,
    parameter int NUM_BASES = 8,
    localparam int SEL_W    = $clog2(NUM_BASES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        base_wr_en,
    input  logic [SEL_W-1:0]            base_wr_idx,
    input  logic [ADDR_W-1:0]           base_wr_data,
    input  logic                        start,
    input  logic [SEL_W-1:0]            base_sel,
    input  logic [1:0]                  cfg_kind,
    input  logic [NDIM-1:0][EXT_W-1:0]  cfg_extent,
    input  logic [NDIM-1:1][ADDR_W-1:0] cfg_stride,
    input  logic                        addr_ready,
    output logic                        addr_valid,
    output logic [ADDR_W-1:0]           addr,
    output logic                        addr_last,
    output logic                        busy,
    output logic                        cfg_err
);
    elem_kind_e                  kind_in;
    launch_chk_t                 chk;
    logic                        cfg_bad;
    logic                        cfg_empty;
    logic                        launch;
    logic                        go;
    logic                        fire;
    logic                        walk_step;
    logic [ADDR_W-1:0]           sel_base;
    logic [NDIM-1:0][EXT_W-1:0]  ext_q;
    logic [NDIM-1:1][ADDR_W-1:0] stride_q;
    logic [1:0]                  esz_q;
    logic [NDIM-1:0]             bump;
    logic                        col_wrap;
    logic                        walk_last;

    assign kind_in = elem_kind_e'(cfg_kind);

    twalk_base_bank #(.AW(ADDR_W), .NB(NUM_BASES)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (base_wr_en),
        .wr_idx  (base_wr_idx),
        .wr_data (base_wr_data),
        .rd_idx  (base_sel),
        .rd_data (sel_base)
    );

    twalk_cfg_check #(.AW(ADDR_W), .EW(EXT_W)) u_check (
        .kind   (kind_in),
        .extent (cfg_extent),
        .stride (cfg_stride),
        .chk    (chk)
    );

    assign cfg_bad   = chk.bad_kind | chk.bad_align;
    assign cfg_empty = chk.empty;
    assign launch    = start && !busy;
    assign go        = launch && !cfg_bad && !cfg_empty;
    assign fire      = busy && addr_ready;
    assign walk_step = fire && !walk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cfg_err  <= 1'b0;
            ext_q    <= '0;
            stride_q <= '0;
            esz_q    <= 2'd1;
        end else if (launch) begin
            busy    <= go;
            cfg_err <= cfg_bad;
            if (go) begin
                ext_q    <= cfg_extent;
                stride_q <= cfg_stride;
                esz_q    <= elem_bytes(kind_in);
            end
        end else if (fire && walk_last) begin
            busy <= 1'b0;
        end
    end

    twalk_odometer #(.EW(EXT_W)) u_odo (
        .clk      (clk),
        .rst      (rst),
        .load     (go),
        .step     (walk_step),
        .ext      (ext_q),
        .bump     (bump),
        .col_wrap (col_wrap),
        .last     (walk_last)
    );

    twalk_addr_accum #(.AW(ADDR_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load   (go),
        .base   (sel_base),
        .step   (walk_step),
        .bump   (bump),
        .esz    (esz_q),
        .stride (stride_q),
        .addr   (addr)
    );

    assign addr_valid = busy;
    assign addr_last  = busy && walk_last;
endmodule

// File: rtl/twalk_checker.sv
module twalk_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          addr_ready,
    input logic          addr_valid,
    input logic [AW-1:0] addr,
    input logic          addr_last,
    input logic          busy,
    input logic          cfg_err,
    input logic          cfg_bad,
    input logic          cfg_empty,
    input logic          col_wrap,
    input logic [1:0]    esz
);
    // R8: a stalled address is held
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_last)));

    // R3: column steps by the element size
    a_r3_column_step: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && !addr_last && !col_wrap)
        |=> (addr == $past(addr) + {{(AW-2){1'b0}}, $past(esz)}));

    // R6: accepting the last element ends the walk
    a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && addr_last) |=> (!busy && !addr_valid));

    // R4: a refused start raises the error and stays idle
    a_r4_refuse: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_bad) |=> (cfg_err && !busy && !addr_valid));

    // R4: no address while the error is up
    a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !addr_valid);

    // R7: an empty walk emits nothing
    a_r7_empty: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !cfg_bad && cfg_empty) |=> (!busy && !addr_valid && !cfg_err));

    // R10: a valid start offers an address next cycle
    a_r10_first: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !cfg_bad && !cfg_empty) |=> addr_valid);

    // R9: start during a walk does not end it early
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(addr_ready && addr_last)) |=> busy);
endmodule

bind tensor_addr_walker twalk_checker #(.AW(ADDR_W)) u_twalk_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .addr_ready (addr_ready),
    .addr_valid (addr_valid),
    .addr       (addr),
    .addr_last  (addr_last),
    .busy       (busy),
    .cfg_err    (cfg_err),
    .cfg_bad    (cfg_bad),
    .cfg_empty  (cfg_empty),
    .col_wrap   (col_wrap),
    .esz        (esz_q)
);

// File: tb/tensor_addr_walker_test.sv
module tensor_addr_walker_test;
    localparam int AW = 32;
    localparam int EW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            base_wr_en = 1'b0;
    logic [2:0]      base_wr_idx = '0;
    logic [AW-1:0]   base_wr_data = '0;
    logic            start = 1'b0;
    logic [2:0]      base_sel = '0;
    logic [1:0]      cfg_kind = '0;
    logic [4:0][EW-1:0] cfg_extent = '0;
    logic [4:1][AW-1:0] cfg_stride = '0;
    logic            addr_ready = 1'b0;
    logic            addr_valid;
    logic [AW-1:0]   addr;
    logic            addr_last;
    logic            busy;
    logic            cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [AW-1:0] bases [8];
    logic [AW-1:0] cur_base;
    int            cur_ext [5];
    logic [AW-1:0] cur_str [5];
    logic [AW-1:0] cur_esz;

    always #4 clk = ~clk;

    tensor_addr_walker #(.ADDR_W(AW), .EXT_W(EW), .NUM_BASES(8)) uut (
        .clk(clk), .rst(rst),
        .base_wr_en(base_wr_en), .base_wr_idx(base_wr_idx), .base_wr_data(base_wr_data),
        .start(start), .base_sel(base_sel), .cfg_kind(cfg_kind),
        .cfg_extent(cfg_extent), .cfg_stride(cfg_stride),
        .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
        .addr_last(addr_last), .busy(busy), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int n);
        int rem = n;
        logic [AW-1:0] a = cur_base;
        int i0 = rem % cur_ext[0]; rem = rem / cur_ext[0];
        a = a + AW'(i0) * cur_esz;
        for (int d = 1; d < 5; d++) begin
            int id = rem % cur_ext[d];
            rem = rem / cur_ext[d];
            a = a + AW'(id) * cur_str[d];
        end
        return a;
    endfunction

    task automatic set_cfg(input int kind, input int e0, input int e1, input int e2,
                           input int e3, input int e4, input logic [AW-1:0] s1,
                           input logic [AW-1:0] s2, input logic [AW-1:0] s3,
                           input logic [AW-1:0] s4);
        cfg_kind      = 2'(kind);
        cfg_extent[0] = EW'(e0); cfg_extent[1] = EW'(e1); cfg_extent[2] = EW'(e2);
        cfg_extent[3] = EW'(e3); cfg_extent[4] = EW'(e4);
        cfg_stride[1] = s1; cfg_stride[2] = s2; cfg_stride[3] = s3; cfg_stride[4] = s4;
        cur_ext[0] = e0; cur_ext[1] = e1; cur_ext[2] = e2; cur_ext[3] = e3; cur_ext[4] = e4;
        cur_str[1] = s1; cur_str[2] = s2; cur_str[3] = s3; cur_str[4] = s4;
        cur_esz = (kind == 2) ? 32'd2 : 32'd1;
    endtask

    task automatic pulse_start(input int sel);
        base_sel = 3'(sel);
        cur_base = bases[sel];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check(!addr_valid, "R1", "valid after reset", {31'b0, addr_valid}, 0);
        check(!busy, "R1", "busy after reset", {31'b0, busy}, 0);
        check(!cfg_err, "R1", "err after reset", {31'b0, cfg_err}, 0);
    endtask

    task automatic t_load_bases();
        for (int i = 0; i < 8; i++) begin
            bases[i] = 32'h1000_0000 + 32'(i) * 32'h0011_0100 + 32'(i);
            if (i == 7) bases[i] = 32'hFFFF_FF80;
        end
        for (int i = 0; i < 8; i++) begin
            base_wr_en = 1'b1; base_wr_idx = 3'(i); base_wr_data = bases[i];
            @(negedge clk);
        end
        base_wr_en = 1'b0;
    endtask

    // rmode 0: always ready, 1: ready with gaps. poke: start pulse and input scramble mid-walk
    task automatic t_walk(input int sel, input int rmode, input bit poke, input string req);
        int total = cur_ext[0] * cur_ext[1] * cur_ext[2] * cur_ext[3] * cur_ext[4];
        int n = 0;
        int cyc = 0;
        bit stall = 0;
        logic [AW-1:0] hold_addr = '0;
        logic hold_last = 0;
        pulse_start(sel);
        check(addr_valid == 1'b1, "R10", "valid after start", {31'b0, addr_valid}, 1);
        check(addr == cur_base, "R10", "first address is base", addr, cur_base);
        if (poke) begin
            cfg_extent = '1;
            cfg_stride = {4{32'h0000_0013}};
            cfg_kind   = 2'd3;
            base_sel   = 3'(sel + 1);
        end
        while (n < total && cyc < 4000) begin
            if (stall) begin
                check(addr_valid && addr == hold_addr && addr_last == hold_last, "R8",
                      "stalled output held", addr, hold_addr);
            end
            addr_ready = (rmode == 0) ? 1'b1 : (((cyc * 7) % 5) > 1);
            start = (poke && cyc == 3) ? 1'b1 : 1'b0;
            if (addr_valid && addr_ready) begin
                check(addr == exp_addr(n), req, $sformatf("address %0d", n), addr, exp_addr(n));
                check(addr_last == (n == total - 1), "R6", $sformatf("last flag at %0d", n),
                      {31'b0, addr_last}, {31'b0, (n == total - 1)});
                n++;
                stall = 0;
            end else begin
                stall = addr_valid;
                hold_addr = addr;
                hold_last = addr_last;
            end
            @(negedge clk);
            cyc++;
        end
        addr_ready = 1'b0;
        start = 1'b0;
        check(n == total, req, "element count", 32'(n), 32'(total));
        check(!busy && !addr_valid, "R6", "idle after last", {31'b0, busy}, 0);
    endtask

    task automatic t_refused(input string req, input string what);
        pulse_start(1);
        check(cfg_err, req, {what, " raises error"}, {31'b0, cfg_err}, 1);
        for (int i = 0; i < 4; i++) begin
            check(!addr_valid && !busy, req, {what, " issues nothing"}, {31'b0, addr_valid}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_bases();

        // R2 R5 R9: u8 walk across every level, inputs disturbed mid-walk
        set_cfg(0, 3, 2, 2, 1, 2, 32'h40, 32'h100, 32'h400, 32'h1000);
        t_walk(0, 0, 1, "R2");

        // R3 R8: float16 walk with stalls, different base
        set_cfg(2, 4, 3, 1, 2, 1, 32'h80, 32'hC0, 32'h1000, 32'h2000);
        t_walk(5, 1, 0, "R3");

        // R11: signed 8-bit walk crossing 2^32
        set_cfg(1, 5, 2, 1, 1, 3, 32'h40, 32'h0, 32'h0, 32'h100);
        t_walk(7, 1, 0, "R11");

        // R6: single element walk, last on first
        set_cfg(0, 1, 1, 1, 1, 1, 32'h40, 32'h40, 32'h40, 32'h40);
        t_walk(3, 0, 0, "R6");

        // R4: misaligned depth stride
        set_cfg(0, 2, 2, 2, 2, 2, 32'h40, 32'h80, 32'h1020, 32'h2000);
        t_refused("R4", "misaligned stride");

        // R4: accepted start clears the error
        set_cfg(0, 2, 1, 1, 1, 1, 32'h40, 32'h40, 32'h40, 32'h40);
        t_walk(2, 0, 0, "R5");
        check(!cfg_err, "R4", "error cleared by good start", {31'b0, cfg_err}, 0);

        // R3: unknown element kind
        set_cfg(3, 2, 2, 1, 1, 1, 32'h40, 32'h40, 32'h40, 32'h40);
        t_refused("R3", "unknown kind");

        // R7: zero extent in depth
        set_cfg(0, 2, 2, 2, 0, 2, 32'h40, 32'h80, 32'h100, 32'h200);
        pulse_start(4);
        for (int i = 0; i < 3; i++) begin
            check(!busy && !addr_valid && !cfg_err, "R7", "empty walk stays idle",
                  {29'b0, busy, addr_valid, cfg_err}, 0);
            @(negedge clk);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule